// File: doc/BRIEF.md
# Supervisory Reset and Chip-Enable Gate

This block is the clocked logic of a processor supervisor. It merges two fault sources into one reset and drives that reset on two complementary pins: a synchronized supply-fail flag from an outside voltage comparator, and an active-low pushbutton or logic-driven manual reset. After every fault has gone away, the reset is held for a fixed number of clock cycles before it is released. The same hold also applies when the block leaves its own asynchronous power-on reset.

The block also sits between the processor's active-low chip-select and a non-volatile memory. Outside reset it passes the select through unchanged. While reset is active it keeps the memory deselected. A select that is already active when reset begins is allowed to continue for a short, bounded grace window so that a write in progress can complete. After that the select is forced inactive until reset ends.

The manual-reset pin is asynchronous and can bounce. It passes through a two-flop synchronizer and a debounce filter before it can start a reset. All hold, debounce and grace times are parameters counted in clock cycles.

Top module: `supv_reset_gate`

## Requirements
- R1: While `supply_fail_i` is 1, `rst_n_o` is 0 in the same cycle, with no register delay.
- R2: A low level on `mr_n_i` that lasts DEB_CYC or more cycles asserts reset. Reset appears exactly DEB_CYC+2 rising clock edges after the pin goes low (two synchronizer edges plus the debounce count).
- R3: A low pulse on `mr_n_i` that lasts DEB_CYC-1 cycles or fewer has no effect on `rst_n_o`.
- R4: Once every fault source is inactive, reset stays asserted for HOLD_CYC more rising edges and releases on the HOLD_CYC-th edge. A fault that returns during this hold restarts the full count.
- R5: While the block reset `rst_n` is low, reset is asserted. After `rst_n` goes high, reset releases on the HOLD_CYC-th rising edge.
- R6: `rst_o` is always the logical inverse of `rst_n_o`.
- R7: Outside reset, `ce_n_o` equals `ce_n_i` in the same cycle. `ce_n_o` is 0 only when `ce_n_i` is 0.
- R8: If `ce_n_i` is 1 when reset asserts, `ce_n_o` stays 1 until reset releases, whatever `ce_n_i` does.
- R9: If `ce_n_i` is 0 when reset asserts, `ce_n_o` stays 0 through the assertion cycle and the next GRACE_CYC rising edges. It is then forced to 1 on the following edge.
- R10: If `ce_n_i` rises during the grace window, `ce_n_o` goes to 1 at once. It stays 1 until reset releases, even if `ce_n_i` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block (power-on) reset |
| supply_fail_i | input | 1 | Synchronized supply-fail flag, active high |
| mr_n_i | input | 1 | Asynchronous manual-reset request, active low, idles high |
| ce_n_i | input | 1 | Processor chip-select for the memory, active low |
| rst_n_o | output | 1 | Supervisory reset, active low |
| rst_o | output | 1 | Supervisory reset, active high |
| ce_n_o | output | 1 | Gated memory chip-select, active low |

## Verification
The hardest situation to reach is the forced release of a chip-select that was already active when reset struck. To reach it, the stimulus has to lower the select and start a fault on the same cycle, then count edges precisely through the grace window. It then toggles the select inside and after the window to show that a blocked select cannot reopen. A second hard case is the edge between a rejected manual-reset glitch and an accepted press. The bench drives pulses one cycle shorter than the debounce length and exactly at the acceptance edge, with the two synchronizer stages included in the count.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    CE_PASS  = 2'd0,
    CE_GRACE = 2'd1,
    CE_BLOCK = 2'd2
  } ce_state_e;

  // Bits needed to hold the values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Hold is finished when the count sits on its last value
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int DEB_CYC = 250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_i,
  output logic mr_fault_o
);
  import supv_pkg::*;

  localparam int W = cnt_w(DEB_CYC);

  logic         sync1_q, sync2_q;
  logic         stable_q;
  logic [W-1:0] cnt_q;
  logic         differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= mr_n_i;
      sync2_q <= sync1_q;
    end
  end

  assign differs = (sync2_q != stable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (at_last(32'(cnt_q), DEB_CYC)) begin
      stable_q <= sync2_q;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mr_fault_o = ~stable_q;

endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
  parameter int HOLD_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  output logic rst_act_o
);
  import supv_pkg::*;

  localparam int W = cnt_w(HOLD_CYC);

  logic         held_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else if (fault_i) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else if (held_q) begin
      if (at_last(32'(cnt_q), HOLD_CYC)) begin
        held_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_act_o = held_q | fault_i;

endmodule

// File: rtl/supv_ce_gate.sv
module supv_ce_gate #(
  parameter int GRACE_CYC = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_act_i,
  input  logic ce_n_i,
  output logic ce_n_o,
  output logic blocked_o
);
  import supv_pkg::*;

  localparam int W = cnt_w(GRACE_CYC);

  ce_state_e    st_q, st_d;
  logic [W-1:0] gcnt_q, gcnt_d;

  always_comb begin
    st_d   = st_q;
    gcnt_d = gcnt_q;
    unique case (st_q)
      CE_PASS: begin
        if (rst_act_i) begin
          st_d   = ce_n_i ? CE_BLOCK : CE_GRACE;
          gcnt_d = '0;
        end
      end
      CE_GRACE: begin
        if (!rst_act_i) begin
          st_d = CE_PASS;
        end else if (ce_n_i || at_last(32'(gcnt_q), GRACE_CYC)) begin
          st_d = CE_BLOCK;
        end else begin
          gcnt_d = gcnt_q + 1'b1;
        end
      end
      default: begin
        if (!rst_act_i) st_d = CE_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CE_BLOCK;
      gcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      gcnt_q <= gcnt_d;
    end
  end

  assign blocked_o = (st_q == CE_BLOCK) && rst_act_i;
  assign ce_n_o    = blocked_o ? 1'b1 : ce_n_i;

endmodule

// File: rtl/supv_reset_gate.sv
module supv_reset_gate #(
  parameter int HOLD_CYC  = 10_000_000,
  parameter int DEB_CYC   = 250_000,
  parameter int GRACE_CYC = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_fail_i,
  input  logic mr_n_i,
  input  logic ce_n_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic ce_n_o
);

  logic mr_fault;
  logic any_fault;
  logic rst_act;
  logic ce_blocked;

  supv_mr_filter #(.DEB_CYC(DEB_CYC)) u_mr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mr_n_i     (mr_n_i),
    .mr_fault_o (mr_fault)
  );

  assign any_fault = supply_fail_i | mr_fault;

  supv_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (any_fault),
    .rst_act_o (rst_act)
  );

  supv_ce_gate #(.GRACE_CYC(GRACE_CYC)) u_ce (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_act_i (rst_act),
    .ce_n_i    (ce_n_i),
    .ce_n_o    (ce_n_o),
    .blocked_o (ce_blocked)
  );

  assign rst_n_o = ~rst_act;
  assign rst_o   = rst_act;

endmodule

// File: rtl/supv_reset_gate_chk.sv
module supv_reset_gate_chk #(
  parameter int GRACE_CYC = 750
) (
  input logic clk,
  input logic rst_n,
  input logic supply_fail_i,
  input logic ce_n_i,
  input logic rst_n_o,
  input logic rst_o,
  input logic ce_n_o,
  input logic mr_fault,
  input logic any_fault
);
  localparam int W = $clog2(GRACE_CYC + 3);

  logic [W-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_cnt_q <= '0;
    else if (!rst_n_o && !ce_n_o)   low_cnt_q <= low_cnt_q + 1'b1;
    else                            low_cnt_q <= '0;
  end

  assert_fail_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail_i |-> !rst_n_o);

  assert_mr_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mr_fault |-> !rst_n_o);

  assert_release_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> !$past(any_fault));

  assert_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o == !rst_n_o);

  assert_ce_only_when_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n_o |-> !ce_n_i);

  assert_ce_stays_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_n_o && $past(!rst_n_o) && $past(ce_n_o)) |-> ce_n_o);

  assert_grace_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_n_o && !ce_n_o) |-> (32'(low_cnt_q) <= GRACE_CYC));

endmodule

bind supv_reset_gate supv_reset_gate_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_fail_i (supply_fail_i),
  .ce_n_i        (ce_n_i),
  .rst_n_o       (rst_n_o),
  .rst_o         (rst_o),
  .ce_n_o        (ce_n_o),
  .mr_fault      (mr_fault),
  .any_fault     (any_fault)
);

// File: tb/supv_reset_gate_bench.sv
module supv_reset_gate_bench;

  localparam int HOLD  = 40;
  localparam int DEB   = 8;
  localparam int GRACE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_fail_i = 1'b0;
  logic mr_n_i = 1'b1;
  logic ce_n_i = 1'b1;
  logic rst_n_o, rst_o, ce_n_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  supv_reset_gate #(.HOLD_CYC(HOLD), .DEB_CYC(DEB), .GRACE_CYC(GRACE)) u_supv_reset_gate (
    .clk(clk), .rst_n(rst_n), .supply_fail_i(supply_fail_i), .mr_n_i(mr_n_i),
    .ce_n_i(ce_n_i), .rst_n_o(rst_n_o), .rst_o(rst_o), .ce_n_o(ce_n_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_release(input string req);
    bit ok = 1'b0;
    for (int i = 0; i < 4 * HOLD + 4 * DEB; i++) begin
      if (rst_n_o === 1'b1) begin ok = 1'b1; break; end
      tick(1);
    end
    chk(req, "reset eventually releases", ok, 1'b1);
  endtask

  task automatic t_power_on();
    rst_n = 1'b0;
    tick(3);
    chk("R5", "reset held during block reset", rst_n_o, 1'b0);
    chk("R6", "rst_o inverse during block reset", rst_o, 1'b1);
    rst_n = 1'b1;
    tick(HOLD - 1);
    chk("R5", "still held one edge before end", rst_n_o, 1'b0);
    tick(1);
    chk("R5", "released after HOLD edges", rst_n_o, 1'b1);
    chk("R6", "rst_o inverse after release", rst_o, 1'b0);
  endtask

  task automatic t_supply();
    supply_fail_i = 1'b1;
    #1 chk("R1", "supply fail asserts at once", rst_n_o, 1'b0);
    tick(3);
    supply_fail_i = 1'b0;
    tick(HOLD - 1);
    chk("R4", "held HOLD-1 edges after fault clears", rst_n_o, 1'b0);
    tick(1);
    chk("R4", "released on HOLD-th edge", rst_n_o, 1'b1);
    // restart during hold
    supply_fail_i = 1'b1;
    tick(1);
    supply_fail_i = 1'b0;
    tick(10);
    supply_fail_i = 1'b1;
    tick(1);
    supply_fail_i = 1'b0;
    tick(HOLD - 1);
    chk("R4", "restarted hold still active", rst_n_o, 1'b0);
    tick(1);
    chk("R4", "restarted hold releases on time", rst_n_o, 1'b1);
  endtask

  task automatic t_manual();
    mr_n_i = 1'b0;
    tick(DEB + 1);
    chk("R2", "not yet asserted at DEB+1 edges", rst_n_o, 1'b1);
    tick(1);
    chk("R2", "asserted at DEB+2 edges", rst_n_o, 1'b0);
    mr_n_i = 1'b1;
    wait_release("R2");
    tick(2);
    mr_n_i = 1'b0;
    tick(DEB - 1);
    mr_n_i = 1'b1;
    begin
      logic seen_rst = 1'b0;
      for (int i = 0; i < DEB + 6; i++) begin
        if (rst_n_o !== 1'b1) seen_rst = 1'b1;
        tick(1);
      end
      chk("R3", "short manual pulse ignored", seen_rst, 1'b0);
    end
  endtask

  task automatic t_ce_follow();
    ce_n_i = 1'b0;
    #1 chk("R7", "select passes low outside reset", ce_n_o, 1'b0);
    tick(1);
    ce_n_i = 1'b1;
    #1 chk("R7", "select passes high outside reset", ce_n_o, 1'b1);
    tick(1);
  endtask

  task automatic t_ce_grace();
    ce_n_i = 1'b0;
    supply_fail_i = 1'b1;
    #1 chk("R9", "select kept in assertion cycle", ce_n_o, 1'b0);
    tick(GRACE);
    chk("R9", "select kept at end of grace", ce_n_o, 1'b0);
    tick(1);
    chk("R9", "select forced high after grace", ce_n_o, 1'b1);
    ce_n_i = 1'b1;
    tick(1);
    ce_n_i = 1'b0;
    #1 chk("R10", "forced select ignores toggles", ce_n_o, 1'b1);
    supply_fail_i = 1'b0;
    wait_release("R9");
    #1 chk("R7", "select follows after release", ce_n_o, 1'b0);
    ce_n_i = 1'b1;
    tick(1);
  endtask

  task automatic t_ce_cut();
    ce_n_i = 1'b0;
    supply_fail_i = 1'b1;
    tick(2);
    ce_n_i = 1'b1;
    #1 chk("R10", "select high when input rises in grace", ce_n_o, 1'b1);
    tick(1);
    ce_n_i = 1'b0;
    #1 chk("R10", "select stays high after input returns low", ce_n_o, 1'b1);
    tick(GRACE);
    chk("R10", "select still high later in reset", ce_n_o, 1'b1);
    supply_fail_i = 1'b0;
    ce_n_i = 1'b1;
    wait_release("R10");
  endtask

  task automatic t_ce_idle();
    ce_n_i = 1'b1;
    supply_fail_i = 1'b1;
    tick(1);
    ce_n_i = 1'b0;
    #1 chk("R8", "idle select blocked in reset", ce_n_o, 1'b1);
    tick(GRACE + 3);
    chk("R8", "idle select blocked later in reset", ce_n_o, 1'b1);
    chk("R6", "rst_o inverse during fault", rst_o, 1'b1);
    supply_fail_i = 1'b0;
    wait_release("R8");
    #1 chk("R7", "select reopens after release", ce_n_o, 1'b0);
    ce_n_i = 1'b1;
    tick(1);
  endtask

  initial begin
    #(20 * 100_000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_power_on();
    t_supply();
    t_manual();
    t_ce_follow();
    t_ce_grace();
    t_ce_cut();
    t_ce_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule